// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block fills one cache line from the next memory level over a bus that is only a quarter of a line wide. When the cache reports a miss, the engine captures the miss address, asks the lower level for the line, and assembles the four returning chunks into a line buffer. The processor gets the word it missed on as soon as the chunk that carries it lands, and the rest of the line keeps filling in the background.

Two orderings are supported, chosen per miss. In wrapped mode the request names the chunk that holds the missed word, and the lower level returns that chunk first and then walks forward through the line, wrapping at the end. In linear mode the request names chunk 0, chunks come back in ascending order, and the processor is released once the chunk holding the missed word has arrived. When the fourth chunk has been written, the whole line is shown on the fill port with a one-cycle completion pulse.

Top module: `cwf_refill`

## Requirements
- R1: While reset is asserted and in the cycle after it, `busy`, `req_valid`, `restart_valid` and `fill_done` are low.
- R2: A miss is accepted only at a clock edge where `miss_valid` is high and `busy` is low. `miss_valid` while `busy` is high has no effect on the request, on the restart word or on the line.
- R3: From the cycle after acceptance, `req_valid` is high and `req_addr` holds the line base (miss address with bits [4:0] cleared) plus 8 times the starting chunk. Both stay unchanged until an edge where `req_ready` is high. The starting chunk is miss address bits [4:3] in wrapped mode and 0 in linear mode.
- R4: The k-th chunk taken after the request (k = 0..3) is written to chunk slot (start + k) mod 4. Slot i occupies `fill_line` bits [64*i+63 : 64*i].
- R5: `restart_valid` is a single-cycle pulse in the cycle after the edge that takes the chunk whose slot equals miss address bits [4:3]. `restart_data` is then 32-bit word number (miss address bit 2) of that chunk, where word j is chunk bits [32*j+31 : 32*j].
- R6: In wrapped mode the restart follows the first chunk taken. In linear mode it follows chunk (miss address bits [4:3]) + 1 taken, so it may come in the same cycle as `fill_done`.
- R7: `busy` is high from the cycle after acceptance until the cycle after the fourth chunk is taken. In that cycle `fill_done` pulses for one cycle and `fill_line` holds the complete line.
- R8: `chunk_valid` is ignored while the request is still pending, that is, before the edge where `req_ready` accepts it.
- R9: The ordering mode is taken from `miss_cwf` at the acceptance edge (1 for wrapped, 0 for linear). Later changes of `miss_cwf` do not affect the refill in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss presented by the cache |
| miss_addr | input | ADDR_W | Byte address of the missed word |
| miss_cwf | input | 1 | 1 selects wrapped critical-chunk-first order, 0 selects linear order |
| busy | output | 1 | Refill in progress; new misses are not taken |
| req_valid | output | 1 | Line request to the lower level |
| req_addr | output | ADDR_W | Address of the first chunk requested |
| req_ready | input | 1 | Lower level accepts the request |
| chunk_valid | input | 1 | A returning chunk is present |
| chunk_data | input | WORD_W*CHUNK_WORDS | Returning chunk |
| restart_valid | output | 1 | One-cycle pulse: missed word available |
| restart_data | output | WORD_W | The missed word |
| fill_done | output | 1 | One-cycle pulse: line complete |
| fill_line | output | WORD_W*CHUNK_WORDS*CHUNKS | Assembled line |

## Verification
Almost every internal fault shows up within the same refill. A wrong start slot or a bad chunk counter puts data in the wrong place in `fill_line`, and at the fill pulse the line differs from the reference in whole 64-bit chunks. The same fault moves the restart pulse off its expected cycle or picks the wrong word, and this shows up on the clock where the critical chunk lands. A state machine that leaves its state at the wrong time lets `busy` or `req_valid` differ from the reference on the very next clock, and stray chunks or misses driven during the request phase and during the fill make sure such slips are seen.

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CHUNK_WORDS = 2,
  parameter int CHUNKS      = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 miss_valid,
  input  logic [ADDR_W-1:0]                    miss_addr,
  input  logic                                 miss_cwf,
  output logic                                 busy,
  output logic                                 req_valid,
  output logic [ADDR_W-1:0]                    req_addr,
  input  logic                                 req_ready,
  input  logic                                 chunk_valid,
  input  logic [WORD_W*CHUNK_WORDS-1:0]        chunk_data,
  output logic                                 restart_valid,
  output logic [WORD_W-1:0]                    restart_data,
  output logic                                 fill_done,
  output logic [WORD_W*CHUNK_WORDS*CHUNKS-1:0] fill_line
);
  localparam int CHUNK_W  = WORD_W * CHUNK_WORDS;
  localparam int LINE_W   = CHUNK_W * CHUNKS;
  localparam int BYTE_B   = $clog2(WORD_W / 8);
  localparam int WSEL_W   = $clog2(CHUNK_WORDS);
  localparam int CSEL_W   = $clog2(CHUNKS);
  localparam int CHUNK_LO = BYTE_B + WSEL_W;
  localparam int LINE_LO  = CHUNK_LO + CSEL_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} state_t;

  state_t                    st_q;
  logic [ADDR_W-LINE_LO-1:0] tag_q;
  logic [CSEL_W-1:0]         crit_q, start_q, cnt_q, slot;
  logic [WSEL_W-1:0]         wsel_q;
  logic [LINE_W-1:0]         line_q;
  logic                      accept, take, last;

  assign accept    = miss_valid && (st_q == S_IDLE);
  assign take      = chunk_valid && (st_q == S_FILL);
  assign last      = cnt_q == CSEL_W'(CHUNKS - 1);
  assign slot      = start_q + cnt_q;
  assign busy      = st_q != S_IDLE;
  assign req_valid = st_q == S_REQ;
  assign req_addr  = {tag_q, start_q, {CHUNK_LO{1'b0}}};
  assign fill_line = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      tag_q   <= '0;
      crit_q  <= '0;
      start_q <= '0;
      wsel_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          st_q    <= S_REQ;
          tag_q   <= miss_addr[ADDR_W-1:LINE_LO];
          crit_q  <= miss_addr[LINE_LO-1:CHUNK_LO];
          wsel_q  <= miss_addr[CHUNK_LO-1:BYTE_B];
          start_q <= miss_cwf ? miss_addr[LINE_LO-1:CHUNK_LO] : '0;
          cnt_q   <= '0;
        end
        S_REQ: if (req_ready) st_q <= S_FILL;
        S_FILL: if (take) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q        <= '0;
      restart_valid <= 1'b0;
      restart_data  <= '0;
      fill_done     <= 1'b0;
    end else begin
      restart_valid <= take && (slot == crit_q);
      fill_done     <= take && last;
      if (take) begin
        line_q[slot*CHUNK_W +: CHUNK_W] <= chunk_data;
        if (slot == crit_q) restart_data <= chunk_data[wsel_q*WORD_W +: WORD_W];
      end
    end
  end

  // R5
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> !restart_valid);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fill_done);
  // R3
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  // R3
  req_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req_valid);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
  // R8
  no_restart_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !restart_valid);
endmodule

// File: tb/cwf_refill_bench.sv
module cwf_refill_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_addr = '0;
  logic         miss_cwf = 1'b0;
  logic         req_ready = 1'b0;
  logic         chunk_valid = 1'b0;
  logic [63:0]  chunk_data = '0;
  logic         busy, req_valid, restart_valid, fill_done;
  logic [31:0]  req_addr, restart_data;
  logic [255:0] fill_line;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit comparing = 1'b0;
  bit finished  = 1'b0;

  always #5 clk = ~clk;

  cwf_refill u_cwf_refill (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_cwf(miss_cwf), .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .restart_valid(restart_valid), .restart_data(restart_data),
    .fill_done(fill_done), .fill_line(fill_line)
  );

  // behavioural reference
  bit          m_busy, m_reqv, m_restart, m_done;
  logic [31:0] m_reqaddr, m_rdata;
  logic [63:0] m_line [4];
  int          m_crit, m_word;
  int          order_q [$];

  initial for (int i = 0; i < 4; i++) m_line[i] = '0;

  always @(posedge clk) begin
    m_restart = 1'b0;
    m_done    = 1'b0;
    if (!rst_n) begin
      m_busy = 1'b0; m_reqv = 1'b0; order_q.delete();
      for (int i = 0; i < 4; i++) m_line[i] = '0;
    end else if (!m_busy) begin
      if (miss_valid) begin
        int st;
        m_busy = 1'b1; m_reqv = 1'b1;
        m_crit = int'(miss_addr[4:3]);
        m_word = int'(miss_addr[2]);
        st = miss_cwf ? m_crit : 0;
        m_reqaddr = {miss_addr[31:5], 5'd0} + 32'(st * 8);
        order_q.delete();
        for (int k = 0; k < 4; k++) order_q.push_back((st + k) % 4);
      end
    end else if (m_reqv) begin
      if (req_ready) m_reqv = 1'b0;
    end else if (chunk_valid) begin
      int idx;
      idx = order_q.pop_front();
      m_line[idx] = chunk_data;
      if (idx == m_crit) begin
        m_restart = 1'b1;
        m_rdata = (m_word == 1) ? chunk_data[63:32] : chunk_data[31:0];
      end
      if (order_q.size() == 0) begin
        m_busy = 1'b0; m_done = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (comparing && rst_n) begin
      chk(busy === m_busy, "R7 R2 busy", 256'(busy), 256'(m_busy));
      chk(req_valid === m_reqv, "R3 R8 req_valid", 256'(req_valid), 256'(m_reqv));
      if (m_reqv)
        chk(req_addr === m_reqaddr, "R3 R9 req_addr", 256'(req_addr), 256'(m_reqaddr));
      chk(restart_valid === m_restart, "R5 R6 restart_valid", 256'(restart_valid), 256'(m_restart));
      if (m_restart)
        chk(restart_data === m_rdata, "R5 R2 restart_data", 256'(restart_data), 256'(m_rdata));
      chk(fill_done === m_done, "R7 fill_done", 256'(fill_done), 256'(m_done));
      if (m_done)
        chk(fill_line === {m_line[3], m_line[2], m_line[1], m_line[0]}, "R4 fill_line",
            fill_line, {m_line[3], m_line[2], m_line[1], m_line[0]});
    end
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [63:0] pat(input logic [31:0] base, input int idx);
    logic [31:0] a;
    a = base + 32'(idx * 8);
    return {a ^ 32'h5A5A_0004, a ^ 32'h0000_C3C3};
  endfunction

  task automatic run_fill(input logic [31:0] addr, input bit cwf, input int rdly,
                          input int gap, input bit hold);
    logic [31:0] base;
    int st;
    base = {addr[31:5], 5'd0};
    st = cwf ? int'(addr[4:3]) : 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = addr; miss_cwf = cwf;
    @(negedge clk);
    miss_valid = 1'b0;
    miss_cwf = ~cwf;                                // R9: mode change after acceptance
    if (hold) begin                                 // R2: miss while busy is ignored
      miss_valid = 1'b1; miss_addr = addr ^ 32'h0000_0058;
    end
    if (rdly > 0) begin                             // R8: stray chunk while request pending
      chunk_valid = 1'b1; chunk_data = '1;
      @(negedge clk);
      chunk_valid = 1'b0;
      repeat (rdly - 1) @(negedge clk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (gap) @(negedge clk);
      if (k == 3) miss_valid = 1'b0;
      chunk_valid = 1'b1;
      chunk_data = pat(base, (st + k) % 4);         // R4: wrapped order from start chunk
      @(negedge clk);
      chunk_valid = 1'b0;
    end
    miss_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    chk(busy === 1'b0, "R1 busy", 256'(busy), 256'(0));
    chk(req_valid === 1'b0, "R1 req_valid", 256'(req_valid), 256'(0));
    chk(restart_valid === 1'b0, "R1 restart_valid", 256'(restart_valid), 256'(0));
    chk(fill_done === 1'b0, "R1 fill_done", 256'(fill_done), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && req_valid === 1'b0, "R1 after release", 256'({busy, req_valid}), 256'(0));
    comparing = 1'b1;
    run_fill(32'h1000_0014, 1'b1, 0, 0, 1'b0);     // R6 wrapped, chunk 2 word 1: 2,3,0,1
    run_fill(32'h2000_0034, 1'b0, 0, 0, 1'b0);     // R6 linear, restart after third chunk
    run_fill(32'h3000_0018, 1'b1, 3, 2, 1'b1);     // R8 R2 R9 chunk 3 word 0
    run_fill(32'h4000_003C, 1'b0, 1, 1, 1'b1);     // R6 linear crit 3: restart with done
    run_fill(32'h5000_0000, 1'b1, 0, 1, 1'b0);     // R5 crit 0 word 0
    run_fill(32'h6000_0024, 1'b0, 2, 0, 1'b0);     // R5 linear crit 0 word 1
    for (int i = 0; i < 24; i++)
      run_fill($urandom, i[0], i % 3, (i / 3) % 3, i[1]);
    comparing = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule